// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Probe

This block opens every transaction on an open-drain single-wire bus. A start strobe makes it pull the line low for a long reset interval. It then releases the line and watches it for a fixed observation window. When the window closes, the block reports one of three outcomes: a target answered with a presence pulse, no target answered, or the bus misbehaved. It reports a bus fault when the line has not returned high shortly after release.

The timing is counted in microseconds. A parameterized prescaler turns the system clock into a one-microsecond tick. Two speed classes are supported: regular and overdrive. The class is selected at start and held for the whole sequence. The driver is expected to feed `line_in` from a synchronizer and to turn `drive_low` into an open-drain pull-down. All time points after release are measured from the release instant. The rise check is set early enough that a healthy bus is high by then.

Top module: `bus_reset_probe`

## Requirements
- R1: After reset, `drive_low`, `busy` and `done` are 0, and `status` is 2'b01.
- R2: A `start` seen while idle asserts `drive_low` and `busy` from the next cycle. `drive_low` stays asserted for exactly 480 us at regular speed (`overdrive`=0) or 70 us at overdrive (`overdrive`=1), where one microsecond is `TICK_DIV` clock cycles.
- R3: After release, the observation window lasts exactly 480 us at regular speed or 48 us at overdrive. It ends with `done` high for one cycle, and in that same cycle `busy` is low.
- R4: If `line_in` is low at the first cycle of microsecond 5 after release (microsecond 1 at overdrive), the sequence ends with status 2'b11 (bus fault). This outcome overrides any presence.
- R5: Without a fault, any low level on `line_in` during microseconds 15 to 239 after release (2 to 23 at overdrive) gives status 2'b00 (target present).
- R6: Without a fault and without such a low level, the status is 2'b01 (no target). A low level that lies fully outside the presence window, but not at the rise check point, does not change this result. The code 2'b10 never appears.
- R7: A `start` during a running sequence, and any change of `overdrive` after the sequence has begun, have no effect on the sequence's timing or result.
- R8: `status` changes only in the cycle in which `done` is high. It is written on every completed sequence, fault included, and holds its value until the next completion.
- R9: `drive_low` is only ever asserted while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reset-and-probe sequence when idle |
| overdrive | input | 1 | Speed class sampled at start: 0 regular, 1 overdrive |
| line_in | input | 1 | Synchronized level of the bus line |
| drive_low | output | 1 | Pull the bus line low |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when the result is ready |
| status | output | 2 | 00 present, 01 no target, 11 bus fault |

## Verification
A corrupted phase or microsecond counter shows up directly at the pins. The low pulse or the observation window comes out a whole number of microseconds too long or too short, and the bench measures both intervals in cycles on every sequence. A wrong fault or presence flag is not visible until `done`, which arrives up to 480 us after the event. Line events are therefore placed exactly on the window edges and on the rise check point, so that an off-by-one in any comparison turns into a wrong status code.

// File: rtl/bus_reset_probe.sv
module bus_reset_probe #(
  parameter int TICK_DIV        = 50,
  parameter int RST_LOW_STD_US  = 480,
  parameter int RST_LOW_OD_US   = 70,
  parameter int OBS_STD_US      = 480,
  parameter int OBS_OD_US       = 48,
  parameter int RISE_STD_US     = 5,
  parameter int RISE_OD_US      = 1,
  parameter int PD_BEG_STD_US   = 15,
  parameter int PD_END_STD_US   = 240,
  parameter int PD_BEG_OD_US    = 2,
  parameter int PD_END_OD_US    = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       overdrive,
  input  logic       line_in,
  output logic       drive_low,
  output logic       busy,
  output logic       done,
  output logic [1:0] status
);
  localparam int MAX_LOW = (RST_LOW_STD_US > RST_LOW_OD_US) ? RST_LOW_STD_US : RST_LOW_OD_US;
  localparam int MAX_OBS = (OBS_STD_US > OBS_OD_US) ? OBS_STD_US : OBS_OD_US;
  localparam int MAX_US  = (MAX_LOW > MAX_OBS) ? MAX_LOW : MAX_OBS;
  localparam int US_W    = $clog2(MAX_US + 1);
  localparam int PRE_W   = $clog2(TICK_DIV + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_OBS} phase_t;

  phase_t           phase;
  logic             od_q;
  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us;
  logic             fault_q, seen_q;

  logic [US_W-1:0] low_last, obs_last, rise_at, pd_beg, pd_end;
  assign low_last = od_q ? US_W'(RST_LOW_OD_US - 1) : US_W'(RST_LOW_STD_US - 1);
  assign obs_last = od_q ? US_W'(OBS_OD_US - 1)     : US_W'(OBS_STD_US - 1);
  assign rise_at  = od_q ? US_W'(RISE_OD_US)        : US_W'(RISE_STD_US);
  assign pd_beg   = od_q ? US_W'(PD_BEG_OD_US)      : US_W'(PD_BEG_STD_US);
  assign pd_end   = od_q ? US_W'(PD_END_OD_US)      : US_W'(PD_END_STD_US);

  wire tick     = (pre == PRE_W'(TICK_DIV - 1));
  wire launch   = (phase == S_IDLE) && start;
  wire low_end  = (phase == S_LOW) && tick && (us == low_last);
  wire obs_end  = (phase == S_OBS) && tick && (us == obs_last);
  wire rise_bad = (phase == S_OBS) && (us == rise_at) && (pre == '0) && !line_in;
  wire pd_hit   = (phase == S_OBS) && (us >= pd_beg) && (us < pd_end) && !line_in;

  assign drive_low = (phase == S_LOW);
  assign busy      = (phase != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      od_q    <= 1'b0;
      pre     <= '0;
      us      <= '0;
      fault_q <= 1'b0;
      seen_q  <= 1'b0;
      done    <= 1'b0;
      status  <= 2'b01;
    end else begin
      done <= 1'b0;
      if (phase == S_IDLE || tick) pre <= '0;
      else                         pre <= pre + 1'b1;
      case (phase)
        S_IDLE: if (launch) begin
          phase   <= S_LOW;
          od_q    <= overdrive;
          us      <= '0;
          fault_q <= 1'b0;
          seen_q  <= 1'b0;
        end
        S_LOW: begin
          if (low_end) begin
            phase <= S_OBS;
            us    <= '0;
          end else if (tick) begin
            us <= us + 1'b1;
          end
        end
        S_OBS: begin
          if (rise_bad) fault_q <= 1'b1;
          if (pd_hit)   seen_q  <= 1'b1;
          if (obs_end) begin
            phase <= S_IDLE;
            done  <= 1'b1;
            if (fault_q)     status <= 2'b11;
            else if (seen_q) status <= 2'b00;
            else             status <= 2'b01;
          end else if (tick) begin
            us <= us + 1'b1;
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_reset_probe_chk.sv
module bus_reset_probe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       drive_low,
  input logic       busy,
  input logic       done,
  input logic [1:0] status
);
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && drive_low));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_release_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> busy);

  p_no_code10_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b10);

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(status)));

  p_drive_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> busy);
endmodule

bind bus_reset_probe bus_reset_probe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .drive_low(drive_low),
  .busy(busy), .done(done), .status(status)
);

// File: tb/test_bus_reset_probe.sv
module test_bus_reset_probe;
  localparam int CLK_PERIOD = 10;
  localparam int T = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, overdrive = 1'b0;
  logic drive_low, busy, done;
  logic [1:0] status;
  logic line_in;

  int checks = 0, failures = 0;
  int rel = 0;
  bit armed = 1'b0;
  int t_d = 0, t_l = 0, t_s = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (drive_low) rel <= 0;
    else if (rel < 1000000) rel <= rel + 1;
  end

  assign line_in = !(drive_low || (armed && ((rel < t_s*T) ||
                     (rel >= t_d*T && rel < (t_d + t_l)*T))));

  bus_reset_probe #(.TICK_DIV(T)) i_bus_reset_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .overdrive(overdrive),
    .line_in(line_in), .drive_low(drive_low), .busy(busy), .done(done),
    .status(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // od, target delay us, target length us, stuck-low us, expected status
  localparam int NV = 16;
  localparam int VEC [NV][5] = '{
    '{0, 30, 120, 0, 0},   // R5 normal presence
    '{0,  0,   0, 0, 1},   // R6 silent bus
    '{0,  0,   0, 10, 3},  // R4 line stuck after release
    '{0, 250, 100, 0, 1},  // R6 pulse after window
    '{0, 239,  5, 0, 0},   // R5 last window microsecond
    '{0, 240,  5, 0, 1},   // R6 just past window
    '{0, 10,   5, 0, 1},   // R6 ends just before window
    '{0, 10,   6, 0, 0},   // R5 touches first window microsecond
    '{0,  0,   0, 5, 1},   // R4 high exactly at check point
    '{0,  0,   0, 6, 3},   // R4 still low at check point
    '{1,  3,  10, 0, 0},   // R5 overdrive presence
    '{1,  0,   0, 0, 1},   // R6 overdrive silent
    '{1,  0,   0, 2, 3},   // R4 overdrive stuck
    '{1, 24,   5, 0, 1},   // R6 overdrive past window
    '{1, 23,   1, 0, 0},   // R5 overdrive last microsecond
    '{1,  1,  20, 0, 3}    // R4 fault wins over presence
  };

  task automatic run_seq(input int od, input int d, input int l, input int s,
                         input int exp, input bit disturb);
    int n = 0, m = 0;
    int exp_low = (od != 0) ? 70 : 480;
    int exp_obs = (od != 0) ? 48 : 480;
    t_d = d; t_l = l; t_s = s; armed = 1'b1;
    overdrive = od[0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    while (drive_low && n < 5000) begin
      n++;
      if (disturb && n == 10) begin start = 1'b1; overdrive = ~overdrive; end
      if (disturb && n == 11) start = 1'b0;
      chk(busy == 1'b1, "R2", "busy during low", busy, 1);
      @(negedge clk);
    end
    chk(n == exp_low*T, disturb ? "R7" : "R2", "low cycles", n, exp_low*T);
    while (!done && m < 5000) begin
      m++;
      if (disturb && m == 30) start = 1'b1;
      if (disturb && m == 31) start = 1'b0;
      @(negedge clk);
    end
    chk(m == exp_obs*T, disturb ? "R7" : "R3", "observe cycles", m, exp_obs*T);
    chk(busy == 1'b0, "R3", "busy with done", busy, 0);
    chk(status == exp[1:0], exp == 3 ? "R4" : (exp == 0 ? "R5" : "R6"),
        "status", status, exp);
    @(negedge clk);
    chk(done == 1'b0, "R3", "done width", done, 0);
    armed = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(drive_low == 1'b0, "R1", "drive_low in reset", drive_low, 0);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    chk(status == 2'b01, "R1", "status in reset", status, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 2'b01 && !busy, "R1", "state after reset", status, 1);

    for (int i = 0; i < NV; i++)
      run_seq(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1'b0);

    // R7: restart and speed change during a sequence do nothing
    run_seq(0, 30, 60, 0, 0, 1'b1);
    run_seq(1, 0, 0, 0, 1, 1'b1);

    // R8: status holds while idle, then a fault is reported after a present
    run_seq(0, 20, 80, 0, 0, 1'b0);
    repeat (50) @(negedge clk);
    chk(status == 2'b00, "R8", "status held idle", status, 0);
    chk(!busy && !drive_low, "R9", "idle without drive", drive_low, 0);
    run_seq(1, 0, 0, 3, 3, 1'b0);
    repeat (20) @(negedge clk);
    chk(status == 2'b11, "R8", "fault status held", status, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule